// File: doc/BRIEF.md
# Programmable Almost-Empty Flag Generator

This block produces an active-low "almost empty" status flag for a single queue whose write side and read side may use different word widths: a narrow 20-bit port or a wide 40-bit port. A wide port covers both a 40-bit single-data-rate transfer and a 20-bit double-data-rate transfer. A narrow port is a 20-bit single-data-rate transfer. Write strobes arrive on the write clock and read strobes on the read clock. The flag is generated on the read clock.

The block accounts for fill internally in 20-bit half-word units, so one comparator serves every width pairing. The write count crosses into the read domain as a Gray-coded word count through a two-flop synchronizer. The read side scales that count by the write width.

The offset `n` and both width selections are captured while reset is held. They stay fixed until the next reset. The flag stays low while the queue holds fewer than `n+1` words of the de-assertion unit. That unit is the wider of the two ports.

Top module: `pae_flag_gen`

## Requirements
- R1: While `rst` is high, and after it is released with no writes, `pae_n` is 0 (almost empty).
- R2: `cfg_offset`, `cfg_wr_wide` and `cfg_rd_wide` are sampled only while `rst` is high. Changing them afterwards does not move the flag threshold.
- R3: With equal port widths (`cfg_wr_wide == cfg_rd_wide`, where 1 selects the 40-bit port and 0 the 20-bit port), `pae_n` goes to 1 once `n+1` writes have been made, and not before.
- R4: With a 20-bit write port feeding a 40-bit read port, `pae_n` goes to 1 only after `2*(n+1)` writes.
- R5: With a 40-bit write port feeding a 20-bit read port, `pae_n` goes to 1 after `n+1` writes.
- R6: In steady state, `pae_n` is 1 exactly when the half-words held reach the threshold `(n+1)*k`. Here k is 2 if either port is 40-bit, else 1. A write adds 2 half-words on a 40-bit port and 1 on a 20-bit port. A read removes 2 half-words on a 40-bit port and 1 on a 20-bit port.
- R7: A read sampled at read-clock edge E that brings the fill below the threshold drives `pae_n` to 0 after edge E+2, the third edge counting E. `pae_n` stays 1 after E and E+1.
- R8: A write that reaches the threshold drives `pae_n` to 1 on the fourth read-clock edge after the write-clock edge that sampled it, when the crossing meets setup. A setup miss may add one read clock.
- R9: A read strobe while fewer half-words are available than one read consumes is ignored. Later writes still need the full threshold to raise the flag.
- R10: The write count presented to the read domain changes in at most one bit per write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across several edges of both clocks |
| cfg_wr_wide | input | 1 | Write port width: 1 = 40-bit, 0 = 20-bit; sampled during reset |
| cfg_rd_wide | input | 1 | Read port width: 1 = 40-bit, 0 = 20-bit; sampled during reset |
| cfg_offset | input | OFF_W | Almost-empty offset n; sampled during reset |
| wr_en | input | 1 | One word written per write-clock edge where high |
| rd_en | input | 1 | One word read per read-clock edge where high |
| pae_n | output | 1 | Active-low almost-empty flag, read-clock synchronous |

## Verification
The bench drives the one-write-short and exact-threshold points for all four width pairings, including `n = 0`. A design that scaled the threshold by the wrong port would raise the flag early or late there. It counts read-clock edges after the boundary write and after the boundary read. A missing or extra pipeline or synchronizer stage therefore shows as a flag that moves one edge off.

Reads against an empty queue are followed by a fresh fill, which exposes a counter that underflows. Configuration inputs are changed after reset to catch a design that samples them live. Random traffic is then compared with a half-word fill model.

// File: rtl/pae_pkg.sv
package pae_pkg;

    // Port width selection; the value is the configuration pin level.
    typedef enum logic {
        PW_NARROW = 1'b0,   // 20-bit single data rate
        PW_WIDE   = 1'b1    // 40-bit SDR or 20-bit DDR
    } port_w_e;

    typedef struct packed {
        port_w_e wr_w;
        port_w_e rd_w;
    } width_cfg_t;

    // Register stages between the level comparator and the flag pin.
    localparam int FLAG_STAGES = 2;

    // Half-words moved by one transfer on a port of the given width.
    function automatic logic [1:0] unit_of(port_w_e w);
        return (w == PW_WIDE) ? 2'd2 : 2'd1;
    endfunction

    // Threshold scale: the de-assertion unit is the wider of the two ports.
    function automatic logic scale_is_two(width_cfg_t c);
        return (c.wr_w == PW_WIDE) || (c.rd_w == PW_WIDE);
    endfunction

endpackage

// File: rtl/pae_wr_counter.sv
module pae_wr_counter #(
    parameter int CNT_W = 12
) (
    input  logic             wclk,
    input  logic             rst,
    input  logic             wr_en,
    output logic [CNT_W-1:0] wr_gray
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nx;

    always_comb begin
        bin_nx = bin_q + CNT_W'(1);
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            bin_q   <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            bin_q   <= bin_nx;
            wr_gray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/pae_gray_sync.sv
module pae_gray_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_out[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/pae_rd_tracker.sv
module pae_rd_tracker
    import pae_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OFF_W = 8
) (
    input  logic             rclk,
    input  logic             rst,
    input  logic             cfg_wr_wide,
    input  logic             cfg_rd_wide,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [CNT_W-1:0] wr_words,
    input  logic             rd_en,
    output logic             level_ok,
    output logic             rd_acc,
    output logic [CNT_W-1:0] fill_half,
    output logic [OFF_W-1:0] offset_q
);
    width_cfg_t       cfg_q;
    logic [CNT_W-1:0] rd_half;
    logic [CNT_W-1:0] wr_half;
    logic [CNT_W-1:0] rd_step;
    logic [CNT_W-1:0] n_plus1;
    logic [CNT_W-1:0] thr_half;

    // Configuration is captured only while reset is held.
    always_ff @(posedge rclk) begin
        if (rst) begin
            cfg_q    <= '{wr_w: port_w_e'(cfg_wr_wide), rd_w: port_w_e'(cfg_rd_wide)};
            offset_q <= cfg_offset;
            rd_half  <= '0;
        end else if (rd_acc) begin
            rd_half  <= rd_half + rd_step;
        end
    end

    always_comb begin
        wr_half   = (cfg_q.wr_w == PW_WIDE) ? {wr_words[CNT_W-2:0], 1'b0} : wr_words;
        rd_step   = CNT_W'(unit_of(cfg_q.rd_w));
        fill_half = wr_half - rd_half;
        rd_acc    = rd_en && (fill_half >= rd_step);
        n_plus1   = CNT_W'(offset_q) + CNT_W'(1);
        thr_half  = scale_is_two(cfg_q) ? {n_plus1[CNT_W-2:0], 1'b0} : n_plus1;
        level_ok  = (fill_half >= thr_half);
    end
endmodule

// File: rtl/pae_flag_pipe.sv
module pae_flag_pipe #(
    parameter int STAGES = 2
) (
    input  logic rclk,
    input  logic rst,
    input  logic level_ok,
    output logic pae_n
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge rclk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= level_ok;
            end
        end else begin : g_chain
            always_ff @(posedge rclk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], level_ok};
            end
        end
    endgenerate

    assign pae_n = sh_q[STAGES-1];
endmodule

// File: rtl/pae_flag_gen.sv
module pae_flag_gen
    import pae_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OFF_W = 8
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst,
    input  logic             cfg_wr_wide,
    input  logic             cfg_rd_wide,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             pae_n
);
    logic [CNT_W-1:0] wr_gray;
    logic [CNT_W-1:0] wr_words_s;
    logic [CNT_W-1:0] fill_half;
    logic [OFF_W-1:0] offset_q;
    logic             level_ok;
    logic             rd_acc;

    pae_wr_counter #(.CNT_W(CNT_W)) u_wr (
        .wclk    (wclk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_gray (wr_gray)
    );

    pae_gray_sync #(.W(CNT_W)) u_sync (
        .clk     (rclk),
        .rst     (rst),
        .gray_in (wr_gray),
        .bin_out (wr_words_s)
    );

    pae_rd_tracker #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_rd (
        .rclk        (rclk),
        .rst         (rst),
        .cfg_wr_wide (cfg_wr_wide),
        .cfg_rd_wide (cfg_rd_wide),
        .cfg_offset  (cfg_offset),
        .wr_words    (wr_words_s),
        .rd_en       (rd_en),
        .level_ok    (level_ok),
        .rd_acc      (rd_acc),
        .fill_half   (fill_half),
        .offset_q    (offset_q)
    );

    pae_flag_pipe #(.STAGES(FLAG_STAGES)) u_pipe (
        .rclk     (rclk),
        .rst      (rst),
        .level_ok (level_ok),
        .pae_n    (pae_n)
    );
endmodule

// File: rtl/pae_flag_chk.sv
module pae_flag_chk #(
    parameter int CNT_W = 12,
    parameter int OFF_W = 8
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst,
    input logic [CNT_W-1:0] wr_gray,
    input logic [CNT_W-1:0] wr_words_s,
    input logic [CNT_W-1:0] fill_half,
    input logic [OFF_W-1:0] offset_q,
    input logic             rd_acc,
    input logic             pae_n
);
    // R1: the flag is low on the edge after any reset cycle
    a_r1_reset_low: assert property (@(posedge rclk) rst |=> !pae_n);

    // R2: captured offset does not move once reset is released
    a_r2_offset_frozen: assert property (@(posedge rclk) disable iff (rst)
        !rst |=> $stable(offset_q));

    // R7: a fall of the flag traces back to an accepted read three samples earlier
    a_r7_fall_from_read: assert property (@(posedge rclk) disable iff (rst)
        $fell(pae_n) |-> $past(rd_acc, 3));

    // R8: a rise of the flag traces back to a new synchronized write count
    a_r8_rise_from_write: assert property (@(posedge rclk) disable iff (rst)
        $rose(pae_n) |-> ($past(wr_words_s, 2) != $past(wr_words_s, 3)));

    // R9: guarded reads never drive the fill count negative
    a_r9_no_underflow: assert property (@(posedge rclk) disable iff (rst)
        fill_half[CNT_W-1] == 1'b0);

    // R10: the crossing word changes in at most one bit per write edge
    a_r10_gray_step: assert property (@(posedge wclk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

bind pae_flag_gen pae_flag_chk #(.CNT_W(CNT_W), .OFF_W(OFF_W)) chk_i (
    .wclk       (wclk),
    .rclk       (rclk),
    .rst        (rst),
    .wr_gray    (wr_gray),
    .wr_words_s (wr_words_s),
    .fill_half  (fill_half),
    .offset_q   (offset_q),
    .rd_acc     (rd_acc),
    .pae_n      (pae_n)
);

// File: tb/pae_flag_gen_tb_top.sv
`timescale 1ns/1ps
module pae_flag_gen_tb_top;
    localparam int CNT_W = 12;
    localparam int OFF_W = 8;

    logic             wclk = 1'b0;
    logic             rclk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr_wide = 1'b0;
    logic             cfg_rd_wide = 1'b0;
    logic [OFF_W-1:0] cfg_offset = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             pae_n;

    int n_checks = 0;
    int n_fail   = 0;
    int fill_m   = 0;
    bit done     = 1'b0;

    pae_flag_gen #(.CNT_W(CNT_W), .OFF_W(OFF_W)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .cfg_offset(cfg_offset),
        .wr_en(wr_en), .rd_en(rd_en), .pae_n(pae_n)
    );

    // 125 MHz read clock; write clock offset so edges never coincide
    initial forever #4 rclk = ~rclk;
    initial begin
        #2;
        forever #5 wclk = ~wclk;
    end

    function automatic int thr_writes(bit ww, bit rw, int n);
        return (!ww && rw) ? 2 * (n + 1) : n + 1;
    endfunction

    function automatic int thr_half(bit ww, bit rw, int n);
        return (n + 1) * ((ww || rw) ? 2 : 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input bit ww, input bit rw, input int n);
        @(negedge rclk);
        rst = 1'b1;
        cfg_wr_wide = ww;
        cfg_rd_wide = rw;
        cfg_offset = OFF_W'(n);
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (6) @(negedge rclk);
        check(pae_n == 1'b0, "R1 during reset", int'(pae_n), 0);
        repeat (4) @(negedge rclk);
        rst = 1'b0;
        fill_m = 0;
        repeat (6) @(negedge rclk);
        check(pae_n == 1'b0, "R1 after reset", int'(pae_n), 0);
    endtask

    task automatic wr_pulse();
        @(negedge wclk);
        wr_en = 1'b1;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        #1;
    endtask

    task automatic run_directed(input bit ww, input bit rw, input int n, input bit cfg_poke);
        string tag;
        int tw;
        tag = (ww == rw) ? "R3" : (!ww ? "R4" : "R5");
        tw = thr_writes(ww, rw, n);
        apply_reset(ww, rw, n);
        if (cfg_poke) begin
            // R2: live config changes after reset must be ignored
            cfg_offset = '0;
            cfg_rd_wide = ~rw;
            cfg_wr_wide = ~ww;
        end
        repeat (tw - 1) wr_pulse();
        settle();
        check(pae_n == 1'b0, cfg_poke ? "R2 one short" : {tag, " one short"}, int'(pae_n), 0);
        // boundary write with exact latency (R8)
        @(negedge wclk);
        wr_en = 1'b1;
        @(posedge wclk);
        wr_en <= 1'b0;
        repeat (3) @(posedge rclk);
        #1;
        check(pae_n == 1'b0, "R8 before fourth edge", int'(pae_n), 0);
        @(posedge rclk);
        #1;
        check(pae_n == 1'b1, {tag, " R8 at threshold"}, int'(pae_n), 1);
        // boundary read with exact latency (R7)
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        rd_en <= 1'b0;
        #1;
        check(pae_n == 1'b1, "R7 after E", int'(pae_n), 1);
        @(posedge rclk);
        #1;
        check(pae_n == 1'b1, "R7 after E+1", int'(pae_n), 1);
        @(posedge rclk);
        #1;
        check(pae_n == 1'b0, "R7 after E+2", int'(pae_n), 0);
        // drain past empty, then refill (R9)
        repeat (2 * tw + 4) rd_pulse();
        settle();
        check(pae_n == 1'b0, "R6 drained", int'(pae_n), 0);
        repeat (tw - 1) wr_pulse();
        settle();
        check(pae_n == 1'b0, "R9 refill one short", int'(pae_n), 0);
        wr_pulse();
        settle();
        check(pae_n == 1'b1, "R9 refill at threshold", int'(pae_n), 1);
    endtask

    task automatic run_random(input bit ww, input bit rw, input int n, input int steps);
        int wu, ru, th;
        wu = ww ? 2 : 1;
        ru = rw ? 2 : 1;
        th = thr_half(ww, rw, n);
        apply_reset(ww, rw, n);
        for (int i = 0; i < steps; i++) begin
            if ($urandom_range(0, 1) == 0 && fill_m < 400) begin
                wr_pulse();
                fill_m += wu;
            end else begin
                rd_pulse();
                if (fill_m >= ru) fill_m -= ru;
            end
            settle();
            check(pae_n == (fill_m >= th), "R6 random", int'(pae_n), int'(fill_m >= th));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_directed(1'b0, 1'b0, 3, 1'b1);
        run_directed(1'b1, 1'b1, 2, 1'b0);
        run_directed(1'b0, 1'b1, 4, 1'b0);
        run_directed(1'b1, 1'b0, 5, 1'b0);
        run_directed(1'b0, 1'b1, 0, 1'b0);
        run_directed(1'b1, 1'b0, 0, 1'b0);
        for (int c = 0; c < 4; c++) begin
            run_random(c[0], c[1], int'($urandom_range(0, 12)), 80);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule